// File: doc/BRIEF.md
# Parallel Flash Bus Write Capture

This block is the front end that sits between an external asynchronous memory bus and the synchronous core of a NOR-flash-style memory. It receives three active-low strobes (chip select, output enable, write enable) plus a 16-bit address and a 16-bit write data bus. It works in a clock domain that runs much faster than the bus. Every bus input passes through a two-flop synchronizer. The chip select and write enable strobes are then cleaned of short low glitches. The block classifies each cycle as standby, output disable, read or write.

For a write, the address is taken when the second of the two strobes (chip select, write enable) goes low. The data is taken when the first of them goes high. When the write ends, the block presents the captured pair together with a strobe that lasts one clock. Raising output enable's partner condition, that is, driving output enable low during a write, cancels that write.

The block also tells the pad logic when to drive the data bus. It raises an automatic standby flag after the bus has been quiet for a programmable number of clocks.

Top module: `pfb_bus_front`

## Requirements
- R1: While chip select is high, the bus state reads standby (code 0), the data-drive enable is low, and write enable activity produces no write strobe.
- R2: Chip select low, output enable low and write enable high give the read state (code 2). The data-drive enable is high only in this state.
- R3: Output enable high with chip select low and write enable high gives the output-disable state (code 1), with the data-drive enable low.
- R4: The address reported with a write is the address present at the later falling edge of chip select and write enable. The address must be held for at least GLITCH_CYC+5 clocks after that edge. During an accepted write the bus state reads write (code 3).
- R5: The data reported with a write is the value present at the earlier rising edge of chip select and write enable. Data changes after that edge are not reported.
- R6: Each completed write produces exactly one write strobe, one clock wide, and no other strobe appears.
- R7: A low pulse on write enable or on chip select that is shorter than GLITCH_CYC clocks starts no write and produces no strobe.
- R8: If output enable is low at any point while chip select and write enable are both low, that write is dropped with no strobe. A later clean write is still accepted.
- R9: When every bus input has stayed unchanged for IDLE_CYC clocks, the automatic standby flag rises. An ongoing read keeps the data-drive enable high. Any input change clears the flag within four clocks.
- R10: After reset the bus state is standby, and the data-drive enable, write strobe and standby flag are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_ce_n | input | 1 | Chip select, active low |
| bus_oe_n | input | 1 | Output enable, active low |
| bus_we_n | input | 1 | Write enable, active low |
| bus_addr | input | 16 | Bus address |
| bus_wdata | input | 16 | Bus write data |
| bus_op | output | 2 | Bus state: 0 standby, 1 output disable, 2 read, 3 write |
| dq_oe | output | 1 | Enable for driving the data bus |
| auto_stby | output | 1 | Bus quiet for IDLE_CYC clocks |
| wr_valid | output | 1 | One-clock strobe at the end of an accepted write |
| wr_addr | output | 16 | Captured write address |
| wr_data | output | 16 | Captured write data |

## Verification
The checker continuously verifies several properties:
- the strobe is one clock wide;
- the data-drive enable follows the synchronized output enable and chip select;
- a chip select held high always reads as standby;
- the standby flag is only high after stable inputs.

Several behaviours can only be shown by the bench's scenarios, because they depend on the order and duration of bus edges over many clocks:
- which address and which data value get reported for the two edge orderings;
- the rejection of short strobe pulses;
- the cancellation of writes by output enable.

// File: rtl/pfb_pkg.sv
package pfb_pkg;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 16;

    typedef enum logic [1:0] {
        OP_STANDBY = 2'd0,
        OP_DISABLE = 2'd1,
        OP_READ    = 2'd2,
        OP_WRITE   = 2'd3
    } bus_op_e;

    typedef enum logic [1:0] {
        WR_IDLE   = 2'd0,
        WR_ACTIVE = 2'd1,
        WR_DROP   = 2'd2
    } wr_state_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } wr_beat_t;

    // Inputs are active-low strobes after synchronizing/filtering.
    function automatic bus_op_e classify(logic ce_l, logic oe_l, logic we_l);
        if (ce_l)
            return OP_STANDBY;
        else if (!oe_l && we_l)
            return OP_READ;
        else if (oe_l && !we_l)
            return OP_WRITE;
        else
            return OP_DISABLE;
    endfunction

endpackage

// File: rtl/pfb_sync.sv
module pfb_sync #(
    parameter int W = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= RST_VAL;
            sync_q <= RST_VAL;
        end else begin
            meta_q <= d_i;
            sync_q <= meta_q;
        end
    end

    assign q_o = sync_q;
endmodule

// File: rtl/pfb_deglitch.sv
module pfb_deglitch #(
    parameter int MIN_LOW = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic in_l,
    output logic out_l
);
    localparam int CW = $clog2(MIN_LOW + 1) + 1;
    localparam logic [CW-1:0] LIMIT = CW'(MIN_LOW);

    logic [CW-1:0] run_q;

    // Counts consecutive low samples; saturates at the threshold.
    always_ff @(posedge clk) begin
        if (rst)
            run_q <= '0;
        else if (in_l)
            run_q <= '0;
        else if (run_q != LIMIT)
            run_q <= run_q + 1'b1;
    end

    // Low is passed only once it has persisted; high passes at once.
    assign out_l = (run_q != LIMIT);
endmodule

// File: rtl/pfb_idle_timer.sv
module pfb_idle_timer #(
    parameter int W        = 35,
    parameter int IDLE_CYC = 15
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] bus_i,
    output logic         idle_o
);
    localparam int CW = $clog2(IDLE_CYC + 1) + 1;
    localparam logic [CW-1:0] LIMIT = CW'(IDLE_CYC);

    logic [W-1:0]  prev_q;
    logic [CW-1:0] quiet_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q  <= '0;
            quiet_q <= '0;
        end else begin
            prev_q <= bus_i;
            if (bus_i != prev_q)
                quiet_q <= '0;
            else if (quiet_q != LIMIT)
                quiet_q <= quiet_q + 1'b1;
        end
    end

    assign idle_o = (quiet_q == LIMIT);
endmodule

// File: rtl/pfb_write_fsm.sv
module pfb_write_fsm
    import pfb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_f_l,
    input  logic              we_f_l,
    input  logic              ce_s_l,
    input  logic              we_s_l,
    input  logic              oe_s_l,
    input  logic [ADDR_W-1:0] addr_s,
    input  logic [DATA_W-1:0] data_s,
    output logic              valid_o,
    output wr_beat_t          beat_o
);
    wr_state_e         state_q;
    logic [ADDR_W-1:0] addr_cap_q;
    logic [DATA_W-1:0] data_cap_q;
    logic              valid_q;
    wr_beat_t          beat_q;
    logic              both_low;

    assign both_low = !ce_f_l && !we_f_l;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= WR_IDLE;
            addr_cap_q <= '0;
            data_cap_q <= '0;
            valid_q    <= 1'b0;
            beat_q     <= '0;
        end else begin
            valid_q <= 1'b0;
            // Data tracks the bus while both synchronized strobes are low,
            // so it freezes at whichever strobe rises first.
            if (!ce_s_l && !we_s_l)
                data_cap_q <= data_s;
            case (state_q)
                WR_IDLE: begin
                    if (both_low) begin
                        addr_cap_q <= addr_s;
                        state_q    <= oe_s_l ? WR_ACTIVE : WR_DROP;
                    end
                end
                WR_ACTIVE: begin
                    if (!oe_s_l) begin
                        state_q <= WR_DROP;
                    end else if (!both_low) begin
                        valid_q     <= 1'b1;
                        beat_q.addr <= addr_cap_q;
                        beat_q.data <= data_cap_q;
                        state_q     <= WR_IDLE;
                    end
                end
                WR_DROP: begin
                    if (!both_low)
                        state_q <= WR_IDLE;
                end
                default: state_q <= WR_IDLE;
            endcase
        end
    end

    assign valid_o = valid_q;
    assign beat_o  = beat_q;
endmodule

// File: rtl/pfb_bus_front.sv
module pfb_bus_front
    import pfb_pkg::*;
#(
    parameter int GLITCH_CYC = 3,
    parameter int IDLE_CYC   = 15
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_ce_n,
    input  logic              bus_oe_n,
    input  logic              bus_we_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [1:0]        bus_op,
    output logic              dq_oe,
    output logic              auto_stby,
    output logic              wr_valid,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data
);
    localparam int NCTRL   = 3;
    localparam int NFILT   = 2;
    localparam int PATH_W  = ADDR_W + DATA_W;
    localparam int BUNDLE_W = NCTRL + PATH_W;

    logic [NCTRL-1:0]  ctrl_s;
    logic [PATH_W-1:0] path_s;
    logic [ADDR_W-1:0] addr_s;
    logic [DATA_W-1:0] data_s;
    logic [NFILT-1:0]  filt_in;
    logic [NFILT-1:0]  filt_out;
    bus_op_e           op;
    wr_beat_t          beat;

    pfb_sync #(.W(NCTRL), .RST_VAL({NCTRL{1'b1}})) u_sync_ctrl (
        .clk(clk), .rst(rst),
        .d_i({bus_we_n, bus_oe_n, bus_ce_n}),
        .q_o(ctrl_s)
    );

    pfb_sync #(.W(PATH_W), .RST_VAL('0)) u_sync_path (
        .clk(clk), .rst(rst),
        .d_i({bus_addr, bus_wdata}),
        .q_o(path_s)
    );

    assign {addr_s, data_s} = path_s;

    // Index 0: chip select, index 1: write enable.
    assign filt_in = {ctrl_s[2], ctrl_s[0]};

    for (genvar gi = 0; gi < NFILT; gi++) begin : g_filt
        pfb_deglitch #(.MIN_LOW(GLITCH_CYC)) u_dg (
            .clk(clk), .rst(rst),
            .in_l(filt_in[gi]),
            .out_l(filt_out[gi])
        );
    end

    assign op     = classify(filt_out[0], ctrl_s[1], filt_out[1]);
    assign bus_op = op;
    assign dq_oe  = (op == OP_READ);

    pfb_idle_timer #(.W(BUNDLE_W), .IDLE_CYC(IDLE_CYC)) u_idle (
        .clk(clk), .rst(rst),
        .bus_i({ctrl_s, path_s}),
        .idle_o(auto_stby)
    );

    pfb_write_fsm u_wr (
        .clk(clk), .rst(rst),
        .ce_f_l(filt_out[0]),
        .we_f_l(filt_out[1]),
        .ce_s_l(ctrl_s[0]),
        .we_s_l(ctrl_s[2]),
        .oe_s_l(ctrl_s[1]),
        .addr_s(addr_s),
        .data_s(data_s),
        .valid_o(wr_valid),
        .beat_o(beat)
    );

    assign wr_addr = beat.addr;
    assign wr_data = beat.data;
endmodule

// File: rtl/pfb_bus_front_chk.sv
module pfb_bus_front_chk (
    input logic       clk,
    input logic       rst,
    input logic       bus_ce_n,
    input logic       bus_oe_n,
    input logic       bus_we_n,
    input logic [1:0] bus_op,
    input logic       dq_oe,
    input logic       auto_stby,
    input logic       wr_valid
);
    // R6
    strobe_one_clk_chk: assert property (@(posedge clk) disable iff (rst)
        wr_valid |=> !wr_valid);

    // R1
    ce_high_standby_chk: assert property (@(posedge clk) disable iff (rst)
        $past(bus_ce_n, 3) |-> (bus_op == 2'd0));

    // R2
    drive_needs_ce_chk: assert property (@(posedge clk) disable iff (rst)
        dq_oe |-> !$past(bus_ce_n, 3));

    // R3
    drive_needs_oe_chk: assert property (@(posedge clk) disable iff (rst)
        dq_oe |-> !$past(bus_oe_n, 2));

    // R9
    stby_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        auto_stby |-> ($past(bus_ce_n, 3) == $past(bus_ce_n, 4))
                   && ($past(bus_we_n, 3) == $past(bus_we_n, 4))
                   && ($past(bus_oe_n, 3) == $past(bus_oe_n, 4)));
endmodule

bind pfb_bus_front pfb_bus_front_chk u_chk (
    .clk(clk), .rst(rst),
    .bus_ce_n(bus_ce_n), .bus_oe_n(bus_oe_n), .bus_we_n(bus_we_n),
    .bus_op(bus_op), .dq_oe(dq_oe), .auto_stby(auto_stby),
    .wr_valid(wr_valid)
);

// File: tb/pfb_bus_front_tb_top.sv
module pfb_bus_front_tb_top;
    import pfb_pkg::*;

    localparam int G    = 3;
    localparam int IDLE = 15;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic [ADDR_W-1:0] addr = '0;
    logic [DATA_W-1:0] wdata = '0;
    logic [1:0]        bus_op;
    logic              dq_oe, auto_stby, wr_valid;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data;

    wr_beat_t exp_q[$];
    int n_tests = 0;
    int n_fail  = 0;
    int n_strobes = 0;
    logic prev_valid = 1'b0;

    always #5 clk = ~clk;

    pfb_bus_front #(.GLITCH_CYC(G), .IDLE_CYC(IDLE)) dut_i (
        .clk(clk), .rst(rst),
        .bus_ce_n(ce_n), .bus_oe_n(oe_n), .bus_we_n(we_n),
        .bus_addr(addr), .bus_wdata(wdata),
        .bus_op(bus_op), .dq_oe(dq_oe), .auto_stby(auto_stby),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // Monitor: pops expected beats as strobes appear.
    always @(negedge clk) begin
        if (!rst) begin
            if (wr_valid && prev_valid)
                check(0, "R6", "strobe wider than one clock", 2, 1);
            if (wr_valid) begin
                n_strobes++;
                if (exp_q.size() == 0) begin
                    check(0, "R6", "unexpected strobe", int'(wr_addr), 0);
                end else begin
                    wr_beat_t e;
                    e = exp_q.pop_front();
                    check(wr_addr == e.addr, "R4", "write address", int'(wr_addr), int'(e.addr));
                    check(wr_data == e.data, "R5", "write data", int'(wr_data), int'(e.data));
                end
            end
            prev_valid = wr_valid;
        end
    end

    // Driver: one write with selectable edge orderings.
    task automatic do_write(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d,
                            input bit we_falls_first, input bit we_rises_first);
        wr_beat_t e;
        e.addr = a;
        e.data = d;
        exp_q.push_back(e);
        oe_n  = 1'b1;
        addr  = a;
        wdata = d ^ 16'h5a5a;
        if (we_falls_first) we_n = 1'b0; else ce_n = 1'b0;
        tick(2);
        if (we_falls_first) ce_n = 1'b0; else we_n = 1'b0;
        tick(2);
        wdata = d;
        tick(G + 3);
        check(bus_op == 2'd3, "R4", "bus state during write", int'(bus_op), 3);
        addr = ~a;
        tick(2);
        if (we_rises_first) we_n = 1'b1; else ce_n = 1'b1;
        tick(1);
        wdata = ~d;
        tick(3);
        ce_n = 1'b1;
        we_n = 1'b1;
        tick(8);
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog act=timeout exp=done");
        summary();
    end

    initial begin
        int base;
        tick(4);
        rst = 1'b0;
        tick(1);
        // R10
        check(bus_op == 2'd0, "R10", "reset bus state", int'(bus_op), 0);
        check(dq_oe == 1'b0, "R10", "reset drive", int'(dq_oe), 0);
        check(wr_valid == 1'b0 && auto_stby == 1'b0, "R10", "reset strobe/stby",
              int'({wr_valid, auto_stby}), 0);

        // R1: write enable toggles with chip select high.
        base = n_strobes;
        we_n = 1'b0;
        tick(G + 6);
        check(bus_op == 2'd0, "R1", "standby state", int'(bus_op), 0);
        oe_n = 1'b0;
        we_n = 1'b1;
        tick(5);
        check(dq_oe == 1'b0, "R1", "no drive in standby", int'(dq_oe), 0);
        oe_n = 1'b1;
        tick(6);
        check(n_strobes == base, "R1", "no strobe in standby", n_strobes - base, 0);

        // R2: read.
        addr = 16'h1234;
        ce_n = 1'b0;
        oe_n = 1'b0;
        tick(G + 4);
        check(bus_op == 2'd2, "R2", "read state", int'(bus_op), 2);
        check(dq_oe == 1'b1, "R2", "drive during read", int'(dq_oe), 1);

        // R3: output disable.
        oe_n = 1'b1;
        tick(4);
        check(bus_op == 2'd1, "R3", "disable state", int'(bus_op), 1);
        check(dq_oe == 1'b0, "R3", "no drive when disabled", int'(dq_oe), 0);

        // R9: automatic standby during a held read.
        oe_n = 1'b0;
        tick(IDLE + 8);
        check(auto_stby == 1'b1, "R9", "standby flag after quiet", int'(auto_stby), 1);
        check(dq_oe == 1'b1, "R9", "read still drives", int'(dq_oe), 1);
        addr = 16'h4321;
        tick(4);
        check(auto_stby == 1'b0, "R9", "flag clears on change", int'(auto_stby), 0);
        oe_n = 1'b1;
        ce_n = 1'b1;
        tick(6);

        // R4, R5: all four edge orderings.
        do_write(16'h0555, 16'h00aa, 1'b0, 1'b0);
        do_write(16'h02aa, 16'h0055, 1'b1, 1'b1);
        do_write(16'h8001, 16'hbeef, 1'b0, 1'b1);
        do_write(16'h3ffe, 16'hc0de, 1'b1, 1'b0);

        // R7: short write enable pulse.
        base = n_strobes;
        ce_n = 1'b0;
        tick(4);
        we_n = 1'b0;
        tick(G - 1);
        we_n = 1'b1;
        tick(8);
        check(n_strobes == base, "R7", "short write enable pulse", n_strobes - base, 0);
        // R7: short chip select pulse with write enable held low.
        ce_n = 1'b1;
        tick(4);
        we_n = 1'b0;
        tick(4);
        ce_n = 1'b0;
        tick(G - 1);
        ce_n = 1'b1;
        tick(8);
        we_n = 1'b1;
        tick(4);
        check(n_strobes == base, "R7", "short chip select pulse", n_strobes - base, 0);

        // R8: output enable low mid-write.
        ce_n = 1'b0;
        we_n = 1'b0;
        tick(G + 5);
        oe_n = 1'b0;
        tick(2);
        oe_n = 1'b1;
        tick(3);
        we_n = 1'b1;
        ce_n = 1'b1;
        tick(8);
        check(n_strobes == base, "R8", "aborted write", n_strobes - base, 0);
        do_write(16'h7777, 16'h1111, 1'b0, 1'b0);
        check(n_strobes == base + 1, "R8", "write after abort", n_strobes - base, 1);

        tick(10);
        check(exp_q.size() == 0, "R6", "all writes strobed", exp_q.size(), 0);
        summary();
    end
endmodule